// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel programmed through a byte-wide register interface. Software first writes a control word. The control word names the channel, the access style and the counting mode. Software then writes the 16-bit reload value to the data port as two bytes, low byte first. The channel starts counting on the write that carries the high byte. While the count enable is high, the count drops by one on each clock edge.

There are two counting modes. In the periodic-tick mode the block raises `tick_o` for one cycle in every period. In the tone mode it drives `wave_o` as a square wave, and the `gate` input can silence that wave. A latch command freezes a copy of the live count, which software then reads back as two bytes. The reload for a wanted rate f from an input clock F is (F + f/2) / f. For a 1193182 Hz clock and a 100 Hz rate this gives 11932.

The sequencing is held in a four-state machine:
- IDLE means no count is loaded.
- LOAD_HI means the low byte has been taken and the high byte is awaited.
- COUNT means the channel is running.
- COUNT_HI means the channel is running and the low byte of a replacement reload has been taken.

The transitions are:
- IDLE to LOAD_HI on a data write.
- LOAD_HI to COUNT on a data write, which loads the counter.
- COUNT to COUNT_HI on a data write.
- COUNT_HI to COUNT on a data write, which queues the replacement reload.
- Any state to IDLE on a valid programming word.

Top module: `pit_channel`

## Requirements
- R1: After reset `tick_o` and `wave_o` are 0, the channel is in IDLE, and two data-port reads return 8'h00 and then 8'h00.
- R2: A control word (written with `addr_ctrl`=1) is decoded as follows. Bits [7:6] select the channel, and the word is ignored unless they equal CHAN_ID, which defaults to 0. Bits [5:4]=2'b11 program the channel, and bits [5:4]=2'b00 latch the count. Bits [3:1] give the mode: 3'b010 is the periodic tick and 3'b011 is the tone. Bit 0 must be 0. Any other word is ignored and does not disturb a running count.
- R3: A reload value N is written as two data-port writes (`addr_ctrl`=0), low byte first. The write carrying the high byte loads N into the counter. In tick mode the first tick appears N-1 enabled cycles after that write.
- R4: In tick mode `tick_o` is high for exactly one cycle every N enabled cycles, and the counter reloads by itself. Cycles with `count_en` low neither count nor tick.
- R5: In tone mode `wave_o` is high for ceil(N/2) enabled cycles and low for floor(N/2) enabled cycles, with N of 2 or more. `gate`=0 forces `wave_o` low without disturbing the count.
- R6: A reload rewritten while the channel runs takes effect at the next terminal count. The period already in progress completes at its old length.
- R7: Every valid programming word stops the counter and returns the byte pointer to the low byte.
- R8: A latch command freezes the count as it stood at that write. The next two data-port reads return its low byte and then its high byte.
- R9: While a latched value has not been read out in full, further latch commands are ignored and the value stays frozen.
- R10: A reload value of 0 acts as 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; advances the read byte pointer |
| addr_ctrl | input | 1 | 1 selects the control register, 0 the data port |
| wdata | input | BYTE_W | Write byte |
| rdata | output | BYTE_W | Read byte from the latched or live count |
| count_en | input | 1 | Counting clock enable |
| gate | input | 1 | Enable for the tone output |
| tick_o | output | 1 | One-cycle pulse per period in tick mode |
| wave_o | output | 1 | Square wave in tone mode |

## Verification
The bench targets the following corner cases:
- A reload of 1 or 2, where an off-by-one in the terminal count shows up as a wrong first-tick delay or period.
- Odd tone periods, where swapping the ceiling and floor split inverts the high and low lengths.
- A reload rewritten in mid-period. A design that applies it at once shortens the running period.
- A lone low byte followed by a fresh programming word. A byte pointer that is not reset loads a scrambled value.
- A second latch between the two reads of the first. Honouring it returns a high byte from a newer count.
- A zero reload. Treating zero as zero makes the counter stall or tick at once instead of after 65535 cycles.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD_HI,
        ST_COUNT,
        ST_COUNT_HI
    } pit_state_e;

    typedef enum logic [2:0] {
        MODE_TICK = 3'b010,
        MODE_TONE = 3'b011
    } pit_mode_e;

    typedef struct packed {
        logic prog;
        logic latch;
        logic tone;
    } pit_cmd_t;

endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
    import pit_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter logic [1:0]  CHAN_ID = 2'd0
) (
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] word,
    output pit_cmd_t          cmd
);

    logic [1:0] sel_f;
    logic [1:0] acc_f;
    logic [2:0] mode_f;
    logic       bcd_f;

    assign sel_f  = word[7:6];
    assign acc_f  = word[5:4];
    assign mode_f = word[3:1];
    assign bcd_f  = word[0];

    always_comb begin
        cmd = '0;
        if (ctrl_wr && sel_f == CHAN_ID) begin
            if (acc_f == 2'b00) begin
                cmd.latch = 1'b1;
            end else if (acc_f == 2'b11 && !bcd_f &&
                         (mode_f == MODE_TICK || mode_f == MODE_TONE)) begin
                cmd.prog = 1'b1;
                cmd.tone = (mode_f == MODE_TONE);
            end
        end
    end

endmodule

// File: rtl/pit_count_fsm.sv
module pit_count_fsm
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog,
    input  logic               prog_tone,
    input  logic               data_wr,
    input  logic [CNT_W/2-1:0] wdata,
    input  logic               count_en,
    input  logic               gate,
    output logic               tick_o,
    output logic               wave_o,
    output logic               run,
    output logic [CNT_W:0]     cnt,
    output logic [CNT_W:0]     period
);

    localparam int BYTE_W = CNT_W / 2;
    localparam int EXT_W  = CNT_W + 1;
    localparam logic [EXT_W-1:0] FULL_SPAN = {1'b1, {CNT_W{1'b0}}};
    localparam logic [EXT_W-1:0] ONE       = EXT_W'(1);

    pit_state_e        state, state_nxt;
    logic              tone_mode;
    logic [BYTE_W-1:0] lo_byte;
    logic [EXT_W-1:0]  pend;
    logic              pend_vld;
    logic [CNT_W-1:0]  full_val;
    logic [EXT_W-1:0]  ext_val;
    logic              terminal;
    logic [EXT_W-1:0]  next_load;

    assign full_val  = {wdata, lo_byte};
    assign ext_val   = (full_val == '0) ? FULL_SPAN : {1'b0, full_val};
    assign run       = (state == ST_COUNT) || (state == ST_COUNT_HI);
    assign terminal  = run && count_en && (cnt == ONE);
    assign next_load = pend_vld ? pend : period;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (data_wr) state_nxt = ST_LOAD_HI;
            ST_LOAD_HI:  if (data_wr) state_nxt = ST_COUNT;
            ST_COUNT:    if (data_wr) state_nxt = ST_COUNT_HI;
            ST_COUNT_HI: if (data_wr) state_nxt = ST_COUNT;
        endcase
        if (prog) state_nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_mode <= 1'b0;
            lo_byte   <= '0;
            pend      <= '0;
            pend_vld  <= 1'b0;
            cnt       <= '0;
            period    <= '0;
        end else begin
            if (data_wr && (state == ST_IDLE || state == ST_COUNT))
                lo_byte <= wdata;

            if (data_wr && state == ST_LOAD_HI) begin
                cnt    <= ext_val;
                period <= ext_val;
            end else if (terminal) begin
                cnt      <= next_load;
                period   <= next_load;
                pend_vld <= 1'b0;
            end else if (run && count_en) begin
                cnt <= cnt - ONE;
            end

            if (data_wr && state == ST_COUNT_HI) begin
                pend     <= ext_val;
                pend_vld <= 1'b1;
            end

            if (prog) begin
                tone_mode <= prog_tone;
                pend_vld  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        tick_o = !tone_mode && terminal;
        wave_o = tone_mode && gate && (!run || (cnt > (period >> 1)));
    end

endmodule

// File: rtl/pit_readback.sv
module pit_readback #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog,
    input  logic               latch_cmd,
    input  logic               data_rd,
    input  logic [CNT_W-1:0]   live,
    output logic [CNT_W/2-1:0] rdata,
    output logic               latched,
    output logic [CNT_W-1:0]   snap
);

    localparam int BYTE_W = CNT_W / 2;

    logic             rd_hi;
    logic [CNT_W-1:0] src;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
            snap    <= '0;
            rd_hi   <= 1'b0;
        end else if (prog) begin
            latched <= 1'b0;
            rd_hi   <= 1'b0;
        end else begin
            if (data_rd) begin
                rd_hi <= !rd_hi;
                if (latched && rd_hi) latched <= 1'b0;
            end
            if (latch_cmd && !latched) begin
                snap    <= live;
                latched <= 1'b1;
                rd_hi   <= 1'b0;
            end
        end
    end

    assign src   = latched ? snap : live;
    assign rdata = rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int         BYTE_W  = 8,
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              count_en,
    input  logic              gate,
    output logic              tick_o,
    output logic              wave_o
);

    localparam int CNT_W = 2 * BYTE_W;

    pit_cmd_t         cmd;
    logic             ctrl_wr, data_wr, data_rd;
    logic             run_w, latched_w;
    logic [CNT_W:0]   cnt_w, period_w;
    logic [CNT_W-1:0] snap_w;

    assign ctrl_wr = wr_en && addr_ctrl;
    assign data_wr = wr_en && !addr_ctrl;
    assign data_rd = rd_en && !addr_ctrl;

    pit_cmd_decode #(.BYTE_W(BYTE_W), .CHAN_ID(CHAN_ID)) u_dec (
        .ctrl_wr (ctrl_wr),
        .word    (wdata),
        .cmd     (cmd)
    );

    pit_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog      (cmd.prog),
        .prog_tone (cmd.tone),
        .data_wr   (data_wr),
        .wdata     (wdata),
        .count_en  (count_en),
        .gate      (gate),
        .tick_o    (tick_o),
        .wave_o    (wave_o),
        .run       (run_w),
        .cnt       (cnt_w),
        .period    (period_w)
    );

    pit_readback #(.CNT_W(CNT_W)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog      (cmd.prog),
        .latch_cmd (cmd.latch),
        .data_rd   (data_rd),
        .live      (cnt_w[CNT_W-1:0]),
        .rdata     (rdata),
        .latched   (latched_w),
        .snap      (snap_w)
    );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             count_en,
    input logic             gate,
    input logic             tick_o,
    input logic             wave_o,
    input logic             prog,
    input logic             run,
    input logic [CNT_W:0]   cnt,
    input logic [CNT_W:0]   period,
    input logic             latched,
    input logic [CNT_W-1:0] snap
);

    localparam logic [CNT_W:0] SPAN = {1'b1, {CNT_W{1'b0}}};

    // R4
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> count_en);

    // R4
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !count_en) |=> $stable(cnt));

    // R6
    reload_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_en && cnt == 1 && !prog) |=> (cnt == period));

    // R5
    gate_blocks_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !wave_o);

    // R9
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> (!latched || $stable(snap)));

    // R10
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != 0 && cnt <= period && period <= SPAN));

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .gate     (gate),
    .tick_o   (tick_o),
    .wave_o   (wave_o),
    .prog     (cmd.prog),
    .run      (run_w),
    .cnt      (cnt_w),
    .period   (period_w),
    .latched  (latched_w),
    .snap     (snap_w)
);

// File: tb/tb_pit_channel.sv
module tb_pit_channel;

    localparam int LIMIT = 70000;

    typedef struct packed {
        logic        tone;
        logic [15:0] n;
        logic [16:0] a;   // tick: first-tick delay; tone: high length
        logic [16:0] b;   // tick: period;           tone: low length
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b0, 16'd1,   17'd0,   17'd1},
        '{1'b0, 16'd2,   17'd1,   17'd2},
        '{1'b0, 16'd5,   17'd4,   17'd5},
        '{1'b0, 16'd256, 17'd255, 17'd256},
        '{1'b0, 16'd300, 17'd299, 17'd300},
        '{1'b1, 16'd10,  17'd5,   17'd5},
        '{1'b1, 16'd7,   17'd4,   17'd3},
        '{1'b1, 16'd2,   17'd1,   17'd1},
        '{1'b1, 16'd257, 17'd129, 17'd128}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr_ctrl = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       count_en = 1'b1, gate = 1'b1;
    logic       tick_o, wave_o;

    int checks = 0;
    int fails  = 0;
    int c, h, l, bad;
    logic [7:0] r_lo, r_hi;

    always #5 clk = ~clk;

    pit_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr_ctrl(addr_ctrl), .wdata(wdata), .rdata(rdata),
        .count_en(count_en), .gate(gate), .tick_o(tick_o), .wave_o(wave_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic ctl, input logic [7:0] d);
        addr_ctrl = ctl; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        addr_ctrl = 1'b0; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic program_ch(input logic tone);
        wr(1'b1, {2'b00, 2'b11, (tone ? 3'b011 : 3'b010), 1'b0});
    endtask

    task automatic load(input logic [15:0] v);
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    task automatic first_tick(output int n);
        n = 0;
        while (!tick_o && n < LIMIT) begin @(negedge clk); n++; end
    endtask

    task automatic next_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_o && n < LIMIT);
    endtask

    task automatic wave_phase(input logic lvl, output int n);
        n = 0;
        while (wave_o == lvl && n < LIMIT) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 tick", tick_o, 0);
        check("R1 wave", wave_o, 0);
        rd(r_lo); rd(r_hi);
        check("R1 read", {r_hi, r_lo}, 0);

        // table: R3 R4 R5 across reloads and modes
        for (int i = 0; i < 9; i++) begin
            program_ch(VEC[i].tone);
            load(VEC[i].n);
            if (!VEC[i].tone) begin
                first_tick(c); check("R3 first tick delay", c, int'(VEC[i].a));
                next_tick(c);  check("R4 tick period", c, int'(VEC[i].b));
            end else begin
                wave_phase(1'b1, h); check("R5 high length", h, int'(VEC[i].a));
                wave_phase(1'b0, l); check("R5 low length", l, int'(VEC[i].b));
                wave_phase(1'b1, h); check("R5 high after reload", h, int'(VEC[i].a));
            end
        end

        // R2 ignored control words keep the count running
        program_ch(1'b0); load(16'd12);
        wr(1'b1, 8'b01_11_010_0);
        wr(1'b1, 8'b00_11_010_1);
        wr(1'b1, 8'b00_11_100_0);
        wr(1'b1, 8'b00_01_010_0);
        next_tick(c);
        next_tick(c); check("R2 period after ignored words", c, 12);
        check("R2 mode unchanged", wave_o, 0);

        // R4 count_en low freezes
        program_ch(1'b0); load(16'd8);
        c = 0; count_en = 1'b0;
        repeat (4) begin @(negedge clk); c++; end
        count_en = 1'b1;
        while (!tick_o && c < LIMIT) begin @(negedge clk); c++; end
        check("R4 frozen delay", c, 11);

        // R6 rewrite in mid-period
        program_ch(1'b0); load(16'd20);
        first_tick(c);
        load(16'd7);
        c = 2;
        while (!tick_o && c < LIMIT) begin @(negedge clk); c++; end
        check("R6 running period kept", c, 20);
        next_tick(c); check("R6 new period", c, 7);

        // R7 pointer reset and stop
        program_ch(1'b0);
        wr(1'b0, 8'h55);
        program_ch(1'b0);
        load(16'd10);
        first_tick(c); check("R7 pointer reset", c, 9);
        program_ch(1'b0);
        bad = 0;
        repeat (30) begin @(negedge clk); if (tick_o) bad++; end
        check("R7 stopped", bad, 0);

        // R8 latch and two-byte read
        program_ch(1'b0); load(16'd1000);
        wr(1'b1, 8'h00);
        repeat (50) @(negedge clk);
        rd(r_lo); rd(r_hi);
        check("R8 latched value", {r_hi, r_lo}, 1000);

        // R9 second latch ignored mid-readout
        program_ch(1'b0); load(16'd1000);
        wr(1'b1, 8'h00);
        rd(r_lo);
        repeat (300) @(negedge clk);
        wr(1'b1, 8'h00);
        rd(r_hi);
        check("R9 frozen value", {r_hi, r_lo}, 1000);
        wr(1'b1, 8'h00);
        rd(r_lo); rd(r_hi);
        check("R9 fresh latch lower", int'({r_hi, r_lo} < 16'd1000 && {r_hi, r_lo} > 16'd0), 1);

        // R5 gate
        program_ch(1'b1); load(16'd10);
        repeat (3) @(negedge clk);
        gate = 1'b0;
        bad = 0;
        repeat (12) begin @(negedge clk); if (wave_o) bad++; end
        check("R5 gate silences", bad, 0);
        gate = 1'b1;
        @(negedge clk);
        wave_phase(1'b1, h);
        wave_phase(1'b0, l);
        wave_phase(1'b1, h); check("R5 gated high", h, 5);
        wave_phase(1'b0, l); check("R5 gated low", l, 5);

        // R10 zero reload acts as 65536
        program_ch(1'b0); load(16'd0);
        first_tick(c); check("R10 zero reload", c, 65535);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule